// File: doc/BRIEF.md
# Mailbox Receiver Window Bank

This block is the receiving side of an inter-processor mailbox. It holds `NUM_WIN` channel windows of 32 bits each; at most 124 are allowed. A remote sender raises status bits through a per-window set vector. Local software reads each window, masks bits it does not want to hear about, and acknowledges events by writing ones to a clear port. One interrupt line summarises every status bit that is not masked.

A small synchronous register bus gives access to the windows and to a frame-level area. The frame area holds a window-count register, an interrupt-enable register, four combined pending-flag words and identification words.

Windows repeat every 0x20 bytes from address 0, so window `w` starts at `w*0x20`. Read data appears on `bus_rdata` one clock after the read request.

Top module: `mbox_rx_frame`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1, `irq_out` is low and `win_pending` is all zero.
- R2: A 1 on `remote_set[32*w+b]` in a cycle sets bit b of the raw status of window w. The raw status reads back at window offset 0x00. Status bits never set themselves in any other way.
- R3: Window offset 0x04 reads the raw status AND NOT the mask.
- R4: A write to window offset 0x08 clears the raw status bits written as 1 and leaves the other bits unchanged.
- R5: Window offset 0x10 reads the mask. A write to offset 0x14 ORs the written ones into the mask. A write to offset 0x18 removes the written ones from the mask. The mask changes only on such writes.
- R6: `irq_out` is high exactly when some window has a status bit set whose mask bit is 0.
- R7: `win_pending[w]` is high when window w has a nonzero masked status. The four words at 0xFA0, 0xFA4, 0xFA8 and 0xFAC carry the same flags: bit n of word k is window 32*k+n.
- R8: 0xF80 reads `NUM_WIN` in bits 6:0. 0xFCC reads the minor revision in bits 3:0 and the major revision in bits 7:4. 0xFC8 reads the identification word.
- R9: 0xF98 is an interrupt-enable register whose bits 2:0 are writable and read back, with bit 2 as the combined-interrupt enable. The other bits read 0. The interrupt status word at 0xF90 reads 0, and writes to 0xF94 change nothing.
- R10: If a remote set and a local clear write hit the same status bit in one cycle, the bit ends up set.
- R11: Unmapped addresses and windows at index `NUM_WIN` or above read as zero, and writes to them have no effect. Writes to window offsets 0x00, 0x04 and 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| remote_set | input | 32*NUM_WIN | Sender-side bit-set pulses, 32 per window |
| win_pending | output | NUM_WIN | One pending flag per window |
| irq_out | output | 1 | Receiver interrupt |

## Verification
The bench builds the frame with `NUM_WIN` = 34. With that count the pending flags run past the first combined word into the second, the third and fourth words must read zero, and window 34 is an unimplemented slot that the bench can address. Every bit of every implemented window is set in turn. A walking unmask across all windows then moves the interrupt and both combined words through each of their flag positions. The cycle where a set and a clear collide, and writes to read-only or unmapped places, are each checked against a model of the status and mask held in the bench.

// File: rtl/mbox_rx_frame.sv
module mbox_rx_frame #(
  parameter int NUM_WIN    = 8,
  parameter int ARCH_MAJOR = 2,
  parameter int ARCH_MINOR = 1,
  parameter logic [31:0] IDENT = 32'h0051_0A3B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [11:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [32*NUM_WIN-1:0]   remote_set,
  output logic [NUM_WIN-1:0]      win_pending,
  output logic                    irq_out
);
  localparam int WORD = 32;
  localparam int TOT  = WORD * NUM_WIN;
  localparam int PAD  = 4 * WORD;

  logic [TOT-1:0] raw_flat, mask_flat;
  logic [PAD-1:0] pend_pad;
  logic [2:0]     int_en_q;
  logic [31:0]    rd_val;

  wire       wr      = bus_en & bus_we;
  wire [6:0] win_sel = bus_addr[11:5];
  wire [4:0] woff    = bus_addr[4:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    wire         hit  = wr && (win_sel == 7'(w));
    wire  [31:0] clr  = (hit && woff == 5'h08) ? bus_wdata : 32'h0;
    wire  [31:0] mset = (hit && woff == 5'h14) ? bus_wdata : 32'h0;
    wire  [31:0] mclr = (hit && woff == 5'h18) ? bus_wdata : 32'h0;
    logic [31:0] raw_q, mask_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        raw_q  <= '0;
        mask_q <= '1;
      end else begin
        raw_q  <= (raw_q & ~clr) | remote_set[WORD*w +: WORD];
        mask_q <= (mask_q | mset) & ~mclr;
      end
    end

    assign raw_flat[WORD*w +: WORD]  = raw_q;
    assign mask_flat[WORD*w +: WORD] = mask_q;
    assign win_pending[w] = |(raw_q & ~mask_q);
  end

  assign irq_out  = |win_pending;
  assign pend_pad = PAD'(win_pending);

  always_ff @(posedge clk) begin
    if (!rst_n)
      int_en_q <= '0;
    else if (wr && bus_addr == 12'hF98)
      int_en_q <= bus_wdata[2:0];
  end

  always_comb begin
    rd_val = '0;
    if (int'(win_sel) < NUM_WIN) begin
      case (woff)
        5'h00: rd_val = raw_flat[WORD*int'(win_sel) +: WORD];
        5'h04: rd_val = raw_flat[WORD*int'(win_sel) +: WORD] &
                        ~mask_flat[WORD*int'(win_sel) +: WORD];
        5'h10: rd_val = mask_flat[WORD*int'(win_sel) +: WORD];
        default: rd_val = '0;
      endcase
    end else begin
      case (bus_addr)
        12'hF80: rd_val = {25'h0, 7'(NUM_WIN)};
        12'hF98: rd_val = {29'h0, int_en_q};
        12'hFA0, 12'hFA4, 12'hFA8, 12'hFAC:
                 rd_val = pend_pad[WORD*int'(bus_addr[3:2]) +: WORD];
        12'hFC8: rd_val = IDENT;
        12'hFCC: rd_val = {24'h0, 4'(ARCH_MAJOR), 4'(ARCH_MINOR)};
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_en && !bus_we)
      bus_rdata <= rd_val;
  end
endmodule

// File: rtl/mbox_rx_frame_chk.sv
module mbox_rx_frame_chk #(
  parameter int NUM_WIN = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [32*NUM_WIN-1:0] remote_set,
  input logic [32*NUM_WIN-1:0] raw_flat,
  input logic [32*NUM_WIN-1:0] mask_flat,
  input logic [NUM_WIN-1:0]    win_pending,
  input logic                  irq_out
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && win_pending == '0));

  p_set_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_set != '0) |=> ((raw_flat & $past(remote_set)) == $past(remote_set)));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_set == '0) |=> ((raw_flat & ~$past(raw_flat)) == '0));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we) |=> $stable(mask_flat));

  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((raw_flat & ~mask_flat) != '0));

  p_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pending == '0) |-> !irq_out);
endmodule

bind mbox_rx_frame mbox_rx_frame_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .remote_set(remote_set), .raw_flat(raw_flat), .mask_flat(mask_flat),
  .win_pending(win_pending), .irq_out(irq_out)
);

// File: tb/tb_mbox_rx_frame.sv
module tb_mbox_rx_frame;
  localparam int NW = 34;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [32*NW-1:0] remote_set = '0;
  logic [NW-1:0] win_pending;
  logic irq_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_raw [NW];
  logic [31:0] m_mask[NW];

  always #10 clk = ~clk;

  mbox_rx_frame #(.NUM_WIN(NW), .ARCH_MAJOR(2), .ARCH_MINOR(1),
                  .IDENT(32'h0051_0A3B)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .remote_set(remote_set), .win_pending(win_pending), .irq_out(irq_out));

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] comb_word(int k);
    logic [31:0] v = '0;
    for (int n = 0; n < 32; n++)
      if (32*k + n < NW) v[n] = |(m_raw[32*k+n] & ~m_mask[32*k+n]);
    return v;
  endfunction

  function automatic logic any_irq();
    logic v = 0;
    for (int w = 0; w < NW; w++) v |= |(m_raw[w] & ~m_mask[w]);
    return v;
  endfunction

  task automatic chk_win(int w, string tag);
    logic [31:0] d;
    rd(12'(w*32 + 'h00), d); check32({tag, " raw"}, d, m_raw[w]);
    rd(12'(w*32 + 'h04), d); check32({tag, " masked"}, d, m_raw[w] & ~m_mask[w]);
    rd(12'(w*32 + 'h10), d); check32({tag, " mask"}, d, m_mask[w]);
  endtask

  task automatic chk_summary(string tag);
    logic [31:0] d;
    check32({tag, " irq R6"}, 32'(irq_out), 32'(any_irq()));
    for (int k = 0; k < 4; k++) begin
      rd(12'hFA0 + 12'(4*k), d);
      check32({tag, " combined R7"}, d, comb_word(k));
    end
    check32({tag, " pend0 R7"}, 32'(win_pending[31:0]), comb_word(0));
    check32({tag, " pend1 R7"}, 32'(win_pending[NW-1:32]), comb_word(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int w = 0; w < NW; w++) begin m_raw[w] = '0; m_mask[w] = '1; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check32("R1 irq", 32'(irq_out), 0);
    check32("R1 pending", 32'(win_pending != '0), 0);
    for (int w = 0; w < NW; w++) chk_win(w, "R1");

    // R2: every bit of every window set by the remote side
    for (int w = 0; w < NW; w++)
      for (int b = 0; b < 32; b++) begin
        @(negedge clk); remote_set[32*w+b] = 1;
        @(negedge clk); remote_set = '0;
        m_raw[w][b] = 1;
        rd(12'(w*32), d); check32("R2 raw set", d, m_raw[w]);
        check32("R6 masked no irq", 32'(irq_out), 0);
      end

    // R3/R5/R6/R7: walking unmask across windows
    for (int w = 0; w < NW; w++) begin
      int b = (w * 7) % 32;
      wr(12'(w*32 + 'h18), 32'(1) << b); m_mask[w][b] = 0;
      chk_win(w, "R3 R5 unmask");
      chk_summary("R7 unmask");
      wr(12'(w*32 + 'h14), 32'(1) << b); m_mask[w][b] = 1;
      check32("R5 remask irq R6", 32'(irq_out), 0);
    end

    // R4: partial clear
    for (int w = 0; w < NW; w++) begin
      logic [31:0] pat = 32'hA5A5_0F0F ^ 32'(w);
      wr(12'(w*32 + 'h08), pat); m_raw[w] &= ~pat;
      rd(12'(w*32), d); check32("R4 clear", d, m_raw[w]);
    end

    // R6: unmask several windows, then clear their status
    wr(12'h000 + 'h18, 32'hFFFF_FFFF); m_mask[0] = '0;
    wr(12'(33*32 + 'h18), 32'h0000_00F0); m_mask[33] &= ~32'hF0;
    chk_summary("R6 multi");
    wr(12'h008, 32'hFFFF_FFFF); m_raw[0] = '0;
    chk_summary("R6 one left");
    wr(12'(33*32 + 'h08), 32'hFFFF_FFFF); m_raw[33] = '0;
    chk_summary("R6 all clear");
    check32("R6 low", 32'(irq_out), 0);

    // R10: remote set and local clear collide
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 12'(5*32 + 'h08); bus_wdata = '1;
    remote_set[32*5+3] = 1;
    @(negedge clk); bus_en = 0; bus_we = 0; remote_set = '0;
    m_raw[5] = 32'h8;
    rd(12'(5*32), d); check32("R10 set wins", d, 32'h8);

    // R8: identification area
    rd(12'hF80, d); check32("R8 count", d, 32'd34);
    rd(12'hFCC, d); check32("R8 arch", d, 32'h21);
    rd(12'hFC8, d); check32("R8 ident", d, 32'h0051_0A3B);

    // R9: interrupt enable and status
    rd(12'hF98, d); check32("R9 en reset", d, 0);
    wr(12'hF98, 32'hFFFF_FFFF);
    rd(12'hF98, d); check32("R9 en rw", d, 32'h7);
    wr(12'hF98, 32'h4);
    rd(12'hF98, d); check32("R9 combined en", d, 32'h4);
    wr(12'hF94, 32'hFFFF_FFFF);
    rd(12'hF90, d); check32("R9 status", d, 0);
    chk_win(5, "R9 clear no effect");

    // R11: unmapped and read-only places
    wr(12'(NW*32 + 'h18), 32'hFFFF_FFFF);
    rd(12'(NW*32 + 'h10), d); check32("R11 no window", d, 0);
    rd(12'(NW*32), d); check32("R11 no window raw", d, 0);
    rd(12'hF84, d); check32("R11 unmapped", d, 0);
    rd(12'h00C, d); check32("R11 hole", d, 0);
    wr(12'(6*32 + 'h00), 32'hFFFF_FFFF);
    wr(12'(6*32 + 'h04), 32'hFFFF_FFFF);
    wr(12'(6*32 + 'h10), 32'h0);
    chk_win(6, "R11 read-only");
    chk_summary("R11 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule